// File: doc/BRIEF.md
# Trap entry sequencer

This block performs the state update a processor makes when it takes a trap. A request carries a 9-bit trap type together with the current trap level, state word, hypervisor state word, window pointer, spill-room counter, global level, program counters and both trap base registers. In one clock edge the block raises the trap level. It pushes the pre-trap context onto a per-level trap stack and rewrites the state word according to the class of the trap. It moves the window pointer for clean-window, spill and fill traps and forms the handler address and its successor.

When the level is one below the limit, the step to the top level also sets the reduced-error bit. A request made at or above the limit changes nothing and sets a sticky error flag instead. A build option adds hypervisor behaviour: a per-level copy of the hypervisor state word, promotion to hyper-privilege, and vectoring through the hypervisor base register. A second option counts the global register level up on each trap. The surrounding pipeline presents a request for one cycle and reads the updated registers once `done` pulses. It can read back any stack level through a combinational read port.

Top module: `trap_entry_seq`

## Requirements
- R1: A request with `cur_tl` >= MAX_TL (default 6) produces no `done` and leaves every `nxt_*` output unchanged. It sets `err_state` one cycle later, and `err_state` stays set until reset.
- R2: A request with `cur_tl` < MAX_TL gives `nxt_tl` = `cur_tl`+1. Bit 5 of `nxt_pstate` (reduced-error) is set exactly when `cur_tl` >= MAX_TL-1.
- R3: After an accepted request, reading level `nxt_tl` through `rd_lvl` returns the pre-trap state word, window pointer, pc, npc and trap type.
- R4: Without the hypervisor option, the new state word is built as follows, apart from bit 5: 0x814 for trap type 0x060; 0x414 for types 0x008, 0x030 and 0x064..0x06F; 0x015 for all other types. The bits are privileged = bit 2, FPU-enable = bit 4, alternate globals = bit 0, MMU globals = bit 10 and interrupt globals = bit 11.
- R5: The window pointer changes only for three trap kinds, each result taken modulo NWIN (default 8). A clean-window trap (type 0x024) gives cwp-2. A spill trap (type & 0x1C0 == 0x080) gives cwp-cansave-2. A fill trap (type & 0x1C0 == 0x0C0) gives cwp+1.
- R6: When not vectoring through the hypervisor base, `nxt_pc` = (`tba` with bits 14:0 cleared) | (bit 14 if the new level > 1) | (type << 5).
- R7: When vectoring through the hypervisor base, `nxt_pc` = (`htba` with bits 13:0 cleared) | (type << 5). This vectoring happens when the hypervisor option is built and the updated hypervisor state has bit 2 set.
- R8: `nxt_npc` = `nxt_pc` + 4.
- R9: With the hypervisor option, the following rules apply. Bit 2 of `nxt_hpstate` is set when the new level exceeds 2, for types 0x008, 0x030 and 0x064..0x06F, and for types >= 0x180. The state word becomes 0x014 for that MMU group and stays as it was for types 0x060 and >= 0x180, with bit 5 still applied as in R2. The pre-trap hypervisor state is stored on the stack.
- R10: With the global-level option, `nxt_gl` = `cur_gl`+1 modulo 2^GL_W; without it, `nxt_gl` = `cur_gl`.
- R11: `done` pulses for exactly one cycle after an accepted request, and `busy` equals `done`. A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Trap request strobe |
| req_tt | input | 9 | Trap type |
| cur_tl | input | TL_W | Current trap level |
| cur_pstate | input | 12 | Current state word |
| cur_hpstate | input | 12 | Current hypervisor state word |
| cur_cwp | input | CWP_W | Current window pointer |
| cur_cansave | input | CWP_W | Windows available before a spill |
| cur_gl | input | GL_W | Current global level |
| cur_pc | input | PC_W | Program counter at the trap |
| cur_npc | input | PC_W | Next program counter at the trap |
| tba | input | PC_W | Trap base register |
| htba | input | PC_W | Hypervisor trap base register |
| rd_lvl | input | TL_W | Stack level to read (1..MAX_TL) |
| busy | output | 1 | Update in progress, requests ignored |
| done | output | 1 | Update complete pulse |
| err_state | output | 1 | Sticky error flag |
| nxt_tl | output | TL_W | Updated trap level |
| nxt_pstate | output | 12 | Updated state word |
| nxt_hpstate | output | 12 | Updated hypervisor state word |
| nxt_cwp | output | CWP_W | Updated window pointer |
| nxt_gl | output | GL_W | Updated global level |
| nxt_pc | output | PC_W | Handler address |
| nxt_npc | output | PC_W | Handler successor address |
| rd_pstate | output | 12 | Stacked state word |
| rd_hpstate | output | 12 | Stacked hypervisor state word |
| rd_cwp | output | CWP_W | Stacked window pointer |
| rd_pc | output | PC_W | Stacked pc |
| rd_npc | output | PC_W | Stacked npc |
| rd_tt | output | 9 | Stacked trap type |

## Verification
The level saturation and the class-driven state rewrite fall in the same cycle. The step from MAX_TL-1 to MAX_TL must set the reduced-error bit on top of a state word that the trap class has just replaced. The bench provokes this with a request at level 5, and it judges bit 5 together with the class bits against a behavioural model on every clock. In the same way, the promotion to hyper-privilege at a new level of 3 coincides with vector selection. A clean-window trap at level 2 is therefore checked for both its wrapped window pointer and its hypervisor-base handler address. It is checked against a second instance built without the hypervisor option, which must vector through the ordinary base with bit 14 set.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    localparam int PS_W = 12;
    localparam int TT_W = 9;

    // state word bits
    localparam logic [PS_W-1:0] M_AG   = 12'h001;
    localparam logic [PS_W-1:0] M_PRIV = 12'h004;
    localparam logic [PS_W-1:0] M_PEF  = 12'h010;
    localparam logic [PS_W-1:0] M_RED  = 12'h020;
    localparam logic [PS_W-1:0] M_MG   = 12'h400;
    localparam logic [PS_W-1:0] M_IG   = 12'h800;
    // hypervisor state word bit
    localparam int HS_PRIV = 2;

    localparam logic [TT_W-1:0] TT_IFAULT = 9'h008;
    localparam logic [TT_W-1:0] TT_CLEAN  = 9'h024;
    localparam logic [TT_W-1:0] TT_DFAULT = 9'h030;
    localparam logic [TT_W-1:0] TT_IVEC   = 9'h060;
    localparam logic [TT_W-1:0] TT_MMU_LO = 9'h064;
    localparam logic [TT_W-1:0] TT_MMU_HI = 9'h06F;
    localparam logic [TT_W-1:0] TT_SPILL  = 9'h080;
    localparam logic [TT_W-1:0] TT_FILL   = 9'h0C0;
    localparam logic [TT_W-1:0] TT_HYPER  = 9'h180;
    localparam logic [TT_W-1:0] TT_GRP    = 9'h1C0;

    typedef enum logic [1:0] {CLS_OTHER, CLS_IVEC, CLS_MMU, CLS_HYPER} trap_class_e;
    typedef enum logic [1:0] {WIN_KEEP, WIN_CLEAN, WIN_SPILL, WIN_FILL} win_op_e;

    function automatic trap_class_e trap_classify(logic [TT_W-1:0] tt, logic hv);
        if (hv && tt >= TT_HYPER) return CLS_HYPER;
        if (tt == TT_IVEC) return CLS_IVEC;
        if (tt == TT_IFAULT || tt == TT_DFAULT || (tt >= TT_MMU_LO && tt <= TT_MMU_HI))
            return CLS_MMU;
        return CLS_OTHER;
    endfunction

    function automatic win_op_e trap_win_op(logic [TT_W-1:0] tt);
        if (tt == TT_CLEAN) return WIN_CLEAN;
        if ((tt & TT_GRP) == TT_SPILL) return WIN_SPILL;
        if ((tt & TT_GRP) == TT_FILL) return WIN_FILL;
        return WIN_KEEP;
    endfunction

    // (a + plus - minus) mod n, with minus < 2n
    function automatic int unsigned win_wrap(int unsigned a, int unsigned plus,
                                             int unsigned minus, int unsigned n);
        return (a + plus + 2 * n - minus) % n;
    endfunction

endpackage

// File: rtl/trap_win_adj.sv
module trap_win_adj
    import trap_seq_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int CWP_W = 3
) (
    input  logic [TT_W-1:0]  tt_i,
    input  logic [CWP_W-1:0] cwp_i,
    input  logic [CWP_W-1:0] cansave_i,
    output logic [CWP_W-1:0] cwp_o
);
    always_comb begin
        unique case (trap_win_op(tt_i))
            WIN_CLEAN: cwp_o = CWP_W'(win_wrap(32'(cwp_i), 0, 2, NWIN));
            WIN_SPILL: cwp_o = CWP_W'(win_wrap(32'(cwp_i), 0, 32'(cansave_i) + 2, NWIN));
            WIN_FILL:  cwp_o = CWP_W'(win_wrap(32'(cwp_i), 1, 0, NWIN));
            default:   cwp_o = cwp_i;
        endcase
    end
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
    import trap_seq_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  logic [TT_W-1:0] tt_i,
    input  logic [PC_W-1:0] tba_i,
    input  logic [PC_W-1:0] htba_i,
    input  logic            hyper_i,
    input  logic            upper_half_i,
    output logic [PC_W-1:0] pc_o,
    output logic [PC_W-1:0] npc_o
);
    localparam logic [PC_W-1:0] NORM_MASK = ~PC_W'(15'h7FFF);
    localparam logic [PC_W-1:0] HYP_MASK  = ~PC_W'(14'h3FFF);
    localparam logic [PC_W-1:0] HALF_BIT  = PC_W'(1) << 14;

    logic [PC_W-1:0] offset;
    assign offset = PC_W'(tt_i) << 5;

    always_comb begin
        if (hyper_i)
            pc_o = (htba_i & HYP_MASK) | offset;
        else
            pc_o = (tba_i & NORM_MASK) | (upper_half_i ? HALF_BIT : '0) | offset;
        npc_o = pc_o + PC_W'(4);
    end
endmodule

// File: rtl/trap_stack.sv
module trap_stack #(
    parameter int DEPTH = 6,
    parameter int LVL_W = 3,
    parameter int ENT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_lvl,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [LVL_W-1:0] rd_lvl,
    output logic [ENT_W-1:0] rd_data
);
    // slot i holds the context pushed when entering level i+1
    logic [DEPTH-1:0][ENT_W-1:0] slots;

    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++)
                if (wr_lvl == LVL_W'(i + 1)) slots[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rd_lvl == LVL_W'(i + 1)) rd_data = slots[i];
    end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
    import trap_seq_pkg::*;
#(
    parameter int MAX_TL = 6,
    parameter int NWIN   = 8,
    parameter int PC_W   = 64,
    parameter int GL_W   = 3,
    parameter int HV_EN  = 1,
    parameter int GL_EN  = 1,
    localparam int TL_W  = $clog2(MAX_TL + 1),
    localparam int CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [TT_W-1:0]  req_tt,
    input  logic [TL_W-1:0]  cur_tl,
    input  logic [PS_W-1:0]  cur_pstate,
    input  logic [PS_W-1:0]  cur_hpstate,
    input  logic [CWP_W-1:0] cur_cwp,
    input  logic [CWP_W-1:0] cur_cansave,
    input  logic [GL_W-1:0]  cur_gl,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [PC_W-1:0]  cur_npc,
    input  logic [PC_W-1:0]  tba,
    input  logic [PC_W-1:0]  htba,
    input  logic [TL_W-1:0]  rd_lvl,
    output logic             busy,
    output logic             done,
    output logic             err_state,
    output logic [TL_W-1:0]  nxt_tl,
    output logic [PS_W-1:0]  nxt_pstate,
    output logic [PS_W-1:0]  nxt_hpstate,
    output logic [CWP_W-1:0] nxt_cwp,
    output logic [GL_W-1:0]  nxt_gl,
    output logic [PC_W-1:0]  nxt_pc,
    output logic [PC_W-1:0]  nxt_npc,
    output logic [PS_W-1:0]  rd_pstate,
    output logic [PS_W-1:0]  rd_hpstate,
    output logic [CWP_W-1:0] rd_cwp,
    output logic [PC_W-1:0]  rd_pc,
    output logic [PC_W-1:0]  rd_npc,
    output logic [TT_W-1:0]  rd_tt
);
    localparam int ENT_W = 2 * PS_W + CWP_W + 2 * PC_W + TT_W;

    logic go, fault, upd;
    assign go    = req_valid && !busy;
    assign fault = cur_tl >= TL_W'(MAX_TL);
    assign upd   = go && !fault;

    trap_class_e cls;
    assign cls = trap_classify(req_tt, HV_EN != 0);

    // level step and reduced-error saturation
    logic [TL_W-1:0] tl_n;
    logic            red_n;
    assign tl_n  = (cur_tl < TL_W'(MAX_TL)) ? cur_tl + 1'b1 : cur_tl;
    assign red_n = cur_tl >= TL_W'(MAX_TL - 1);

    // class-dependent state words
    logic [PS_W-1:0] ps_cls, ps_n, hps_n, hps_save;
    if (HV_EN != 0) begin : g_hv
        always_comb begin
            unique case (cls)
                CLS_MMU:   ps_cls = M_PEF | M_PRIV;
                CLS_OTHER: ps_cls = M_PEF | M_PRIV | M_AG;
                default:   ps_cls = cur_pstate;
            endcase
            hps_n = cur_hpstate;
            if (tl_n > TL_W'(2) || cls == CLS_MMU || cls == CLS_HYPER)
                hps_n[HS_PRIV] = 1'b1;
        end
        assign hps_save = cur_hpstate;
    end else begin : g_plain
        always_comb begin
            unique case (cls)
                CLS_IVEC: ps_cls = M_PEF | M_PRIV | M_IG;
                CLS_MMU:  ps_cls = M_PEF | M_PRIV | M_MG;
                default:  ps_cls = M_PEF | M_PRIV | M_AG;
            endcase
            hps_n = cur_hpstate;
        end
        assign hps_save = '0;
    end
    assign ps_n = ps_cls | (red_n ? M_RED : '0);

    logic [GL_W-1:0] gl_n;
    if (GL_EN != 0) begin : g_gl
        assign gl_n = cur_gl + 1'b1;
    end else begin : g_nogl
        assign gl_n = cur_gl;
    end

    logic hyper;
    assign hyper = (HV_EN != 0) && hps_n[HS_PRIV];

    logic [CWP_W-1:0] cwp_n;
    trap_win_adj #(.NWIN(NWIN), .CWP_W(CWP_W)) u_win (
        .tt_i(req_tt), .cwp_i(cur_cwp), .cansave_i(cur_cansave), .cwp_o(cwp_n)
    );

    logic [PC_W-1:0] pc_n, npc_n;
    trap_vec_gen #(.PC_W(PC_W)) u_vec (
        .tt_i(req_tt), .tba_i(tba), .htba_i(htba), .hyper_i(hyper),
        .upper_half_i(tl_n > TL_W'(1)), .pc_o(pc_n), .npc_o(npc_n)
    );

    logic [ENT_W-1:0] wr_word, rd_word;
    assign wr_word = {hps_save, cur_pstate, cur_cwp, cur_pc, cur_npc, req_tt};
    trap_stack #(.DEPTH(MAX_TL), .LVL_W(TL_W), .ENT_W(ENT_W)) u_stack (
        .clk(clk), .rst(rst), .wr_en(upd), .wr_lvl(tl_n), .wr_data(wr_word),
        .rd_lvl(rd_lvl), .rd_data(rd_word)
    );
    assign {rd_hpstate, rd_pstate, rd_cwp, rd_pc, rd_npc, rd_tt} = rd_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            done        <= 1'b0;
            err_state   <= 1'b0;
            nxt_tl      <= '0;
            nxt_pstate  <= '0;
            nxt_hpstate <= '0;
            nxt_cwp     <= '0;
            nxt_gl      <= '0;
            nxt_pc      <= '0;
            nxt_npc     <= '0;
        end else begin
            done <= upd;
            if (go && fault) err_state <= 1'b1;
            if (upd) begin
                nxt_tl      <= tl_n;
                nxt_pstate  <= ps_n;
                nxt_hpstate <= hps_n;
                nxt_cwp     <= cwp_n;
                nxt_gl      <= gl_n;
                nxt_pc      <= pc_n;
                nxt_npc     <= npc_n;
            end
        end
    end
    assign busy = done;

    p_err_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        err_state |=> err_state);
    p_err_noupd_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && cur_tl >= TL_W'(MAX_TL)) |=>
            (err_state && !done && $stable(nxt_pc) && $stable(nxt_tl)));
    p_tl_step_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> nxt_tl == $past(cur_tl) + 1'b1);
    p_red_top_r2: assert property (@(posedge clk) disable iff (rst)
        (done && nxt_tl == TL_W'(MAX_TL)) |-> (nxt_pstate & M_RED) != '0);
    p_pc_align_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> nxt_pc[4:0] == 5'd0);
    p_npc_step_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> nxt_npc == nxt_pc + PC_W'(4));
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> ($stable(nxt_tl) && $stable(nxt_cwp)));
endmodule

// File: tb/trap_entry_seq_test.sv
`timescale 1ns/100ps
module trap_entry_seq_test;
    localparam int MAX_TL = 6;
    localparam int NWIN   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic        req_valid = 1'b0;
    logic [8:0]  req_tt = '0;
    logic [2:0]  cur_tl = '0, cur_cwp = '0, cur_cansave = '0, cur_gl = '0, rd_lvl = '0;
    logic [11:0] cur_pstate = '0, cur_hpstate = '0;
    logic [63:0] cur_pc = '0, cur_npc = '0;
    logic [63:0] tba  = 64'h0000_00AB_CDEF_5678;
    logic [63:0] htba = 64'h0000_0077_0001_3ABC;

    logic        busy, done, err;
    logic [2:0]  tl, cwp, gl, r_cwp;
    logic [11:0] ps, hps, r_ps, r_hps;
    logic [63:0] pc, npc, r_pc, r_npc;
    logic [8:0]  r_tt;
    logic        b_busy, b_done, b_err;
    logic [2:0]  b_tl, b_cwp, b_gl, b_rcwp;
    logic [11:0] b_ps, b_hps, b_rps, b_rhps;
    logic [63:0] b_pc, b_npc, b_rpc, b_rnpc;
    logic [8:0]  b_rtt;

    trap_entry_seq #(.MAX_TL(MAX_TL), .NWIN(NWIN), .HV_EN(1), .GL_EN(1)) uut (
        .clk, .rst, .req_valid, .req_tt, .cur_tl, .cur_pstate, .cur_hpstate, .cur_cwp,
        .cur_cansave, .cur_gl, .cur_pc, .cur_npc, .tba, .htba, .rd_lvl,
        .busy(busy), .done(done), .err_state(err), .nxt_tl(tl), .nxt_pstate(ps),
        .nxt_hpstate(hps), .nxt_cwp(cwp), .nxt_gl(gl), .nxt_pc(pc), .nxt_npc(npc),
        .rd_pstate(r_ps), .rd_hpstate(r_hps), .rd_cwp(r_cwp), .rd_pc(r_pc),
        .rd_npc(r_npc), .rd_tt(r_tt));

    trap_entry_seq #(.MAX_TL(MAX_TL), .NWIN(NWIN), .HV_EN(0), .GL_EN(0)) uut_base (
        .clk, .rst, .req_valid, .req_tt, .cur_tl, .cur_pstate, .cur_hpstate, .cur_cwp,
        .cur_cansave, .cur_gl, .cur_pc, .cur_npc, .tba, .htba, .rd_lvl,
        .busy(b_busy), .done(b_done), .err_state(b_err), .nxt_tl(b_tl), .nxt_pstate(b_ps),
        .nxt_hpstate(b_hps), .nxt_cwp(b_cwp), .nxt_gl(b_gl), .nxt_pc(b_pc), .nxt_npc(b_npc),
        .rd_pstate(b_rps), .rd_hpstate(b_rhps), .rd_cwp(b_rcwp), .rd_pc(b_rpc),
        .rd_npc(b_rnpc), .rd_tt(b_rtt));

    int n_chk = 0, n_fail = 0;
    logic        e_done = 0, e_err = 0;
    logic [63:0] e_tl = 0, e_ps = 0, e_hps = 0, e_cwp = 0, e_gl = 0, e_pc = 0;
    logic [63:0] f_tl = 0, f_ps = 0, f_hps = 0, f_cwp = 0, f_gl = 0, f_pc = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // behavioural model of one trap entry, from the requirements
    task automatic model(input bit hv, input bit gle, output logic [63:0] o_tl, o_ps,
                         o_hps, o_cwp, o_gl, o_pc);
        int t = int'(cur_tl);
        int tt = int'(req_tt);
        int ntl = t + 1;
        int c = int'(cur_cwp);
        bit mmu = (tt == 'h08) || (tt == 'h30) || (tt >= 'h64 && tt <= 'h6F);
        logic [63:0] p = 64'(cur_pstate), h = 64'(cur_hpstate);
        if (hv && tt >= 'h180) h[2] = 1'b1;
        else if (tt == 'h60) p = hv ? p : 64'h814;
        else if (mmu) begin
            p = hv ? 64'h014 : 64'h414;
            if (hv) h[2] = 1'b1;
        end else p = 64'h015;
        if (t >= MAX_TL - 1) p = p | 64'h020;
        if (hv && ntl > 2) h[2] = 1'b1;
        if (tt == 'h24) c = c - 2;
        else if ((tt & 'h1C0) == 'h80) c = c - int'(cur_cansave) - 2;
        else if ((tt & 'h1C0) == 'hC0) c = c + 1;
        c = ((c % NWIN) + NWIN) % NWIN;
        if (hv && h[2]) o_pc = (htba & ~64'h3FFF) | (64'(tt) << 5);
        else o_pc = (tba & ~64'h7FFF) | ((ntl > 1) ? 64'h4000 : 64'h0) | (64'(tt) << 5);
        o_tl = 64'(ntl); o_ps = p; o_hps = h; o_cwp = 64'(c);
        o_gl = gle ? 64'((int'(cur_gl) + 1) % 8) : 64'(cur_gl);
    endtask

    always @(negedge clk) if (!rst) begin
        chk("R11", "done", 64'(done), 64'(e_done));
        chk("R11", "busy", 64'(busy), 64'(e_done));
        chk("R1", "err_state", 64'(err), 64'(e_err));
        chk("R2", "tl", 64'(tl), e_tl);
        chk("R9", "pstate", 64'(ps), e_ps);
        chk("R9", "hpstate", 64'(hps), e_hps);
        chk("R5", "cwp", 64'(cwp), e_cwp);
        chk("R10", "gl", 64'(gl), e_gl);
        chk("R7", "pc", pc, e_pc);
        chk("R8", "npc", npc, e_pc + (e_done || e_tl != 0 ? 64'd4 : 64'd0));
        chk("R11", "base done", 64'(b_done), 64'(e_done));
        chk("R1", "base err", 64'(b_err), 64'(e_err));
        chk("R2", "base tl", 64'(b_tl), f_tl);
        chk("R4", "base pstate", 64'(b_ps), f_ps);
        chk("R5", "base cwp", 64'(b_cwp), f_cwp);
        chk("R10", "base gl", 64'(b_gl), f_gl);
        chk("R6", "base pc", b_pc, f_pc);
        chk("R8", "base npc", b_npc, f_pc + (f_tl != 0 ? 64'd4 : 64'd0));
    end

    task automatic trap(input logic [8:0] tt, input int lvl, input logic [11:0] p, h,
                        input int w, input int cs, input int g, input bit hold2,
                        input logic [8:0] tt2);
        logic [63:0] a_tl, a_ps, a_hps, a_cwp, a_gl, a_pc;
        logic [63:0] c_tl, c_ps, c_hps, c_cwp, c_gl, c_pc;
        bit fault = lvl >= MAX_TL;
        @(negedge clk); #1;
        req_tt = tt; cur_tl = 3'(lvl); cur_pstate = p; cur_hpstate = h;
        cur_cwp = 3'(w); cur_cansave = 3'(cs); cur_gl = 3'(g);
        cur_pc = 64'h4000_0000 + 64'(tt) * 16; cur_npc = cur_pc + 64'd4;
        req_valid = 1'b1;
        model(1'b1, 1'b1, a_tl, a_ps, a_hps, a_cwp, a_gl, a_pc);
        model(1'b0, 1'b0, c_tl, c_ps, c_hps, c_cwp, c_gl, c_pc);
        @(posedge clk); #1;
        if (fault) e_err = 1'b1;
        else begin
            e_done = 1'b1;
            e_tl = a_tl; e_ps = a_ps; e_hps = a_hps; e_cwp = a_cwp; e_gl = a_gl; e_pc = a_pc;
            f_tl = c_tl; f_ps = c_ps; f_hps = c_hps; f_cwp = c_cwp; f_gl = c_gl; f_pc = c_pc;
            rd_lvl = a_tl[2:0];
        end
        if (hold2) req_tt = tt2;   // presented while busy: must be ignored
        else req_valid = 1'b0;
        @(posedge clk); #1;
        req_valid = 1'b0;
        e_done = 1'b0;
        if (hold2) chk("R11", "ignored request cwp", 64'(cwp), e_cwp);
        if (!fault) begin
            chk("R3", "stack pc", r_pc, cur_pc);
            chk("R3", "stack npc", r_npc, cur_npc);
            chk("R3", "stack tt", 64'(r_tt), 64'(tt));
            chk("R3", "stack pstate", 64'(r_ps), 64'(p));
            chk("R3", "stack cwp", 64'(r_cwp), 64'(w));
            chk("R9", "stack hpstate", 64'(r_hps), 64'(h));
            chk("R3", "base stack pc", b_rpc, cur_pc);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk); #1;
        chk("R11", "reset done", 64'(done), 64'd0);
        chk("R2", "reset tl", 64'(tl), 64'd0);
        trap(9'h041, 0, 12'h000, 12'h000, 3, 1, 0, 1'b0, 9'h0);  // other class, low half
        trap(9'h060, 1, 12'h0C4, 12'h000, 3, 1, 1, 1'b0, 9'h0);  // interrupt vector, R4 IG
        trap(9'h068, 1, 12'h0C4, 12'h000, 4, 0, 2, 1'b0, 9'h0);  // MMU miss, R7 via hyper
        trap(9'h024, 2, 12'h015, 12'h000, 1, 0, 3, 1'b0, 9'h0);  // clean wrap, level 3 R9
        trap(9'h0A4, 0, 12'h015, 12'h000, 2, 5, 7, 1'b0, 9'h0);  // spill wrap, gl wrap R10
        trap(9'h0C8, 0, 12'h015, 12'h000, 7, 0, 0, 1'b0, 9'h0);  // fill wrap
        trap(9'h1A0, 0, 12'h0C4, 12'h001, 0, 0, 0, 1'b0, 9'h0);  // hyper range
        trap(9'h041, 4, 12'h000, 12'h000, 2, 0, 0, 1'b0, 9'h0);  // R2 no red yet
        trap(9'h041, 5, 12'h000, 12'h000, 2, 0, 0, 1'b0, 9'h0);  // R2 red at top
        trap(9'h041, 0, 12'h000, 12'h000, 5, 0, 0, 1'b1, 9'h0C8);// R11 busy ignore
        trap(9'h041, 6, 12'h000, 12'h000, 5, 0, 0, 1'b0, 9'h0);  // R1 error, no update
        trap(9'h030, 2, 12'h000, 12'h000, 6, 0, 4, 1'b0, 9'h0);  // R1 sticky, fault class
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule